// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the output stage of a sampling converter that sends its results over a serial link it clocks itself. A free-running master-clock counter splits time into 64-cycle periods. Settling and computation periods alternate, and period 0 is a settling period. The converter presents each finished 20-bit result on a parallel bus with a one-cycle strobe. The block holds that word until it has been shifted out or replaced.

At the first cycle of every computation period the block samples an active-low select. If the select is low and an unsent word is held, the block drives its own serial clock at a quarter of the master rate and shifts the word out, most significant bit first. A transfer can pause, either because the select rises or because the computation period ends. It then resumes with the next unsent bit at a later polled boundary. A ready flag tells the receiver when no fresh word is waiting. Clock and data each have their own output enable, and both are released whenever the block is not transmitting.

Top module: `selfclk_result_tx`

## Requirements
- R1: During and right after reset, `drdy` is 1, `sclk_oe` and `sdata_oe` are 0, and `sclk_o` is 1.
- R2: A transfer starts or resumes only at the first cycle of a computation period. The select is sampled at that cycle, and the enables rise in the cycle after it. A select that goes low at any other time has no effect until the next such poll.
- R3: Each word is sent as 20 bits, bit 19 first and bit 0 last, each bit exactly once.
- R4: While enabled, `sclk_o` is low for two master cycles and high for two. The data changes only when `sclk_o` falls and holds steady while `sclk_o` is high, so successive rising edges are 4 master cycles apart.
- R5: One computation period carries at most 16 bits. A 20-bit word sent with the select held low goes out as a 16-bit burst, followed by a 4-bit burst in the next computation period.
- R6: If the select is high when a bit ends, both enables drop after that bit. The transfer then resumes with the next unsent bit at a later poll that finds the select low.
- R7: `drdy` rises as the last bit ends and stays high, with no further transmission, until a new word arrives.
- R8: A strobe that arrives while the held word is not fully sent drives `drdy` high for exactly 4 master cycles and abandons the old word. `drdy` then falls with the new word loaded, and the new word is sent from its MSB.
- R9: A strobe that arrives while `drdy` is high loads the word at once. `drdy` is low in the next cycle, and the word is sent from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_word | input | 20 | Result word, captured with the strobe |
| cs_n | input | 1 | Active-low select, polled at computation period starts |
| sclk_o | output | 1 | Generated serial clock, idles high |
| sclk_oe | output | 1 | Output enable for the serial clock |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for the serial data |
| drdy | output | 1 | High when no unsent word is held |

## Verification
A wrong bit pointer or shift register shows up in the same word. Bits arrive out of order, or a burst has the wrong length when it closes, within one or two computation periods. A counter phase that is off by even one cycle moves the enable rise away from the poll cycle, so the first burst after reset exposes it. A wrong hold count or a wrong ready update is visible within a handful of cycles of a strobe, measured as the length of the `drdy` pulse.

// File: rtl/selfclk_result_tx.sv
module selfclk_result_tx #(
  parameter int WORD_W   = 20,
  parameter int PHASE_W  = 6,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_word,
  input  logic              cs_n,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              drdy
);
  localparam int CNT_W  = PHASE_W + 1;
  localparam int PTR_W  = $clog2(WORD_W + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [PTR_W-1:0]  LAST_BIT = PTR_W'(WORD_W - 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYC);
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg, stage;
  logic [PTR_W-1:0]  ptr;
  logic [HOLD_W-1:0] hold;
  logic              active, rdy;

  wire phase_zero = cnt[PHASE_W-1:0] == '0;
  wire poll       = cnt[PHASE_W] && phase_zero;
  wire bit_end    = active && cnt[1:0] == 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shreg  <= '0;
      stage  <= '0;
      ptr    <= '0;
      hold   <= '0;
      active <= 1'b0;
      rdy    <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (res_valid) stage <= res_word;
      if (hold != '0) begin
        hold <= hold - 1'b1;
        if (hold == HOLD_ONE) begin
          shreg <= stage;
          ptr   <= '0;
          rdy   <= 1'b0;
        end
      end else if (res_valid && !rdy) begin
        hold   <= HOLD_INIT;
        rdy    <= 1'b1;
        active <= 1'b0;
      end else if (res_valid) begin
        shreg <= res_word;
        ptr   <= '0;
        rdy   <= 1'b0;
      end else if (bit_end) begin
        shreg <= {shreg[WORD_W-2:0], 1'b0};
        ptr   <= ptr + 1'b1;
        if (ptr == LAST_BIT) begin
          rdy    <= 1'b1;
          active <= 1'b0;
        end else if (cs_n || phase_zero) begin
          active <= 1'b0;
        end
      end else if (poll && !cs_n && !rdy) begin
        active <= 1'b1;
      end
    end
  end

  assign sclk_oe  = active;
  assign sdata_oe = active;
  assign sclk_o   = active ? ~(cnt[1] ^ cnt[0]) : 1'b1;
  assign sdata_o  = active ? shreg[WORD_W-1] : 1'b0;
  assign drdy     = rdy;

  a_r2_start_at_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_oe) |-> (cnt[PHASE_W] && cnt[PHASE_W-1:0] == PHASE_W'(1)));

  a_r5_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (cnt[PHASE_W] || phase_zero));

  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && sclk_o && $past(sclk_oe) && $past(sclk_o)) |-> $stable(sdata_o));

  a_r6_stop_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_oe) && hold == '0) |-> $past(cnt[1:0]) == 2'd0);

  a_r8_flag_during_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0) |-> drdy);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy && hold == '0 && !res_valid) |=> drdy);

  a_r9_fresh_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> (ptr == '0 && !sclk_oe));
endmodule

// File: tb/selfclk_result_tx_test.sv
module selfclk_result_tx_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, res_valid = 1'b0, cs_n = 1'b1;
  logic [19:0] res_word = '0;
  logic sclk_o, sclk_oe, sdata_o, sdata_oe, drdy;

  selfclk_result_tx uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
    .cs_n(cs_n), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .drdy(drdy));

  int tcnt = 0;
  int checks = 0, fails = 0;
  bit    exp_bits[$];
  int    exp_bursts[$];
  string exp_tags[$];

  always @(posedge clk) if (rst_n) tcnt <= (tcnt + 1) % 1024;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic push_word(logic [19:0] w);
    for (int i = 19; i >= 0; i--) exp_bits.push_back(w[i]);
  endtask

  task automatic push_burst(int n, string tag);
    exp_bursts.push_back(n);
    exp_tags.push_back(tag);
  endtask

  task automatic strobe(logic [19:0] w);
    @(negedge clk);
    res_word  = w;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic wait_tc(int m, int r);
    @(negedge clk);
    while (tcnt % m != r) @(negedge clk);
  endtask

  task automatic wait_ready(string req);
    int n = 0;
    while (!drdy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(drdy, req, "drdy after transfer", drdy, 1);
  endtask

  // monitor: pops expected bits on each serial clock rise, closes bursts
  logic prev_oe = 1'b0, prev_sclk = 1'b1, prev_sd = 1'b0;
  int burst = 0, last_rise = 0, exp_n = 0;
  string exp_t;
  bit exp_b;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_oe && !prev_oe) begin
        check(tcnt % 128 == 65, "R2", "enable rise cycle", tcnt % 128, 65);
        burst = 0;
      end
      if (sclk_oe && prev_oe && sclk_o && !prev_sclk) begin
        if (exp_bits.size() == 0) check(1'b0, "R3", "unexpected bit", sdata_o, 0);
        else begin
          exp_b = exp_bits.pop_front();
          check(sdata_o == exp_b, "R3", "serial bit", sdata_o, exp_b);
        end
        if (burst > 0)
          check((tcnt - last_rise + 1024) % 1024 == 4, "R4", "rise spacing",
                (tcnt - last_rise + 1024) % 1024, 4);
        last_rise = tcnt;
        burst++;
      end
      if (sclk_oe && prev_oe && sclk_o && prev_sclk)
        check(sdata_o == prev_sd, "R4", "data steady while clock high", sdata_o, prev_sd);
      if (!sclk_oe && prev_oe) begin
        if (exp_bursts.size() == 0) check(1'b0, "R5", "unexpected burst", burst, 0);
        else begin
          exp_n = exp_bursts.pop_front();
          exp_t = exp_tags.pop_front();
          check(burst == exp_n, exp_t, "burst length", burst, exp_n);
        end
      end
      prev_oe   = sclk_oe;
      prev_sclk = sclk_oe ? sclk_o : 1'b1;
      prev_sd   = sdata_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(drdy == 1'b1, "R1", "drdy in reset", drdy, 1);
    check(sclk_oe == 1'b0 && sdata_oe == 1'b0, "R1", "enables in reset", sclk_oe | sdata_oe, 0);
    check(sclk_o == 1'b1, "R1", "clock idle level", sclk_o, 1);
    rst_n = 1'b1;

    // R9 immediate load, R2 late select, R5 split 16+4, R7 sticky ready
    wait_tc(1024, 20);
    push_word(20'hA5C3E);
    push_burst(16, "R5");
    push_burst(4, "R5");
    strobe(20'hA5C3E);
    check(drdy == 1'b0, "R9", "drdy after load", drdy, 0);
    wait_tc(128, 74);
    cs_n = 1'b0;
    @(negedge clk);
    check(sclk_oe == 1'b0, "R2", "no start off poll", sclk_oe, 0);
    wait_ready("R7");
    n = 0;
    repeat (300) begin
      @(negedge clk);
      if (drdy && !sclk_oe) n++;
    end
    check(n == 300, "R7", "ready held with select low", n, 300);
    cs_n = 1'b1;

    // R6 pause mid-word and resume
    push_word(20'h3F0C9);
    push_burst(5, "R6");
    push_burst(15, "R6");
    strobe(20'h3F0C9);
    wait_tc(128, 60);
    cs_n = 1'b0;
    wait_tc(128, 82);
    cs_n = 1'b1;
    wait_tc(128, 90);
    check(sclk_oe == 1'b0 && sdata_oe == 1'b0, "R6", "released after bit", sclk_oe | sdata_oe, 0);
    check(drdy == 1'b0, "R6", "word still pending", drdy, 0);
    wait_tc(128, 10);
    cs_n = 1'b0;
    wait_ready("R6");
    cs_n = 1'b1;

    // R8 overwrite of an unsent word
    strobe(20'h12345);
    repeat (10) @(negedge clk);
    @(negedge clk);
    res_word  = 20'hC0FFE;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    n = 0;
    while (drdy && n < 20) begin
      n++;
      @(negedge clk);
    end
    check(n == 4, "R8", "ready pulse length", n, 4);
    check(drdy == 1'b0, "R8", "ready low after reload", drdy, 0);
    push_word(20'hC0FFE);
    push_burst(16, "R8");
    push_burst(4, "R8");
    wait_tc(128, 10);
    cs_n = 1'b0;
    wait_ready("R8");
    cs_n = 1'b1;
    repeat (8) @(negedge clk);

    check(exp_bits.size() == 0, "R3", "bits left over", exp_bits.size(), 0);
    check(exp_bursts.size() == 0, "R5", "bursts left over", exp_bursts.size(), 0);
    finish_run();
  end
endmodule